// File: doc/BRIEF.md
# L1 Exit Resume Sequencer

This block paces the exit from the L1 low-power link state on a USB-style link. It runs in either the device role or the host role and is told which by a role select. While suspended it reacts to two wake sources: a resume request bit that software writes, and a line-state input that reports resume signaling from the far end. It then enables resume drive for the right length of time, waits a fixed settling interval, and declares the link ready for traffic. It pulses an interrupt at the moment the link becomes usable again.

All timing is counted in ticks of a 1 µs strobe. The host-initiated resume length comes from a 4-bit hold-off code (n). The code is decoded as 50 + 75·n µs, which spans 50 µs to 1175 µs. The remote-wake permission carried by the suspending LPM token is sampled when suspend is entered. Only that sampled copy gates whether a host honours a wake from its device.

Top module: `lpm_resume_seq`

## Requirements
- R1: After reset the link is operational: `ready_o`=1, `drive_resume_o`=0, `resume_irq_o`=0.
- R2: A pulse on `enter_l1_i` while operational suspends the link: `ready_o` drops on the next cycle and `drive_resume_o` stays 0.
- R3: In device role (`role_host_i`=0), a resume request while suspended enables `drive_resume_o` for exactly 50 ticks.
- R4: In device role, after its own drive the block stays not ready until the far end has been seen driving resume and has then stopped. `ready_o` rises 10 ticks after the far end stops.
- R5: In device role, when the far end drives resume on a suspended link without a local request, `drive_resume_o` stays 0 and `ready_o` rises 10 ticks after the far end stops.
- R6: In host role (`role_host_i`=1), a resume request while suspended enables `drive_resume_o` for 50 + 75·n ticks, where n is `hird_i` read as a 4-bit unsigned value at the request. `ready_o` rises 10 ticks after the drive ends.
- R7: In host role, far-end resume on a suspended link is treated as a remote wake if `rwake_tok_i` was 1 when `enter_l1_i` pulsed. The block then drives resume for 60 ticks and becomes ready 10 ticks later.
- R8: In host role, if `rwake_tok_i` was 0 at suspend entry, far-end resume is ignored: the link stays suspended and nothing is driven.
- R9: A resume request written while the link is not suspended (operational, or part way through an exit) has no effect on drive length, readiness or interrupts.
- R10: `resume_irq_o` is a one-cycle pulse that is high exactly in the first cycle of each return to `ready_o`=1, and it pulses once per exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| role_host_i | input | 1 | 1 = host role, 0 = device role |
| enter_l1_i | input | 1 | Pulse: link has entered L1 |
| rwake_tok_i | input | 1 | Remote-wake permission from the suspending token, sampled at `enter_l1_i` |
| res_req_wr_i | input | 1 | One-cycle write of the self-clearing resume request bit |
| hird_i | input | 4 | Resume hold-off code n (50 + 75·n µs) |
| far_resume_i | input | 1 | Far end is driving resume signaling |
| tick_us_i | input | 1 | 1 µs timing strobe |
| drive_resume_o | output | 1 | Enable for local resume signaling |
| ready_o | output | 1 | Link operational, traffic allowed |
| resume_irq_o | output | 1 | Pulse on return to operational state |

## Verification
The embedded assertions guard the cycle-level relations on every clock. Drive and readiness never overlap. The interrupt coincides exactly with the rise of readiness. Requests made while operational leave the link operational. A suspended host without remote-wake permission stays suspended. The interval counter never passes its limit. The device's wait state cannot settle before it has seen far-end resume. Only the directed scenarios can show the absolute durations measured in ticks: 50, 60 and 50 + 75·n for drive, and 10 for settling. They also show that the device waits for the far end to finish, and that a request made mid-exit leaves the drive length unchanged.

// File: rtl/lpm_rsm_pkg.sv
package lpm_rsm_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE   = 3'd0,
    ST_L1       = 3'd1,
    ST_DEV_DRV  = 3'd2,
    ST_DEV_WAIT = 3'd3,
    ST_HST_DRV  = 3'd4,
    ST_HST_RW   = 3'd5,
    ST_SETTLE   = 3'd6
  } rsm_state_e;

endpackage

// File: rtl/lpm_hird_decode.sv
module lpm_hird_decode #(
  parameter int HIRD_W       = 4,
  parameter int HIRD_BASE_US = 50,
  parameter int HIRD_STEP_US = 75,
  parameter int CNT_W        = 11
) (
  input  logic [HIRD_W-1:0] hird_i,
  output logic [CNT_W-1:0]  dur_o
);

  localparam logic [CNT_W-1:0] BASE_V = CNT_W'(HIRD_BASE_US);
  localparam logic [CNT_W-1:0] STEP_V = CNT_W'(HIRD_STEP_US);

  logic [CNT_W-1:0] code_ext;

  always_comb begin
    code_ext = {{(CNT_W-HIRD_W){1'b0}}, hird_i};
    dur_o    = BASE_V + STEP_V * code_ext;
  end

  always_comb begin
    a_dur_min_r6: assert (dur_o >= BASE_V);
  end

endmodule

// File: rtl/lpm_us_timer.sv
module lpm_us_timer #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = start_i | (run_i & tick_i);
    lim_d  = start_i ? limit_i : lim_q;
    if (start_i) cnt_d = '0;
    else         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else begin
      if (cnt_en)  cnt_q <= cnt_d;
      if (start_i) lim_q <= lim_d;
    end
  end

  assign expire_o = run_i & tick_i & (cnt_q == lim_q - 1'b1);

  p_cnt_below_lim_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q < lim_q));

endmodule

// File: rtl/lpm_rsm_ctrl.sv
module lpm_rsm_ctrl
  import lpm_rsm_pkg::*;
#(
  parameter int CNT_W         = 11,
  parameter int DEV_DRIVE_US  = 50,
  parameter int HOST_RWAKE_US = 60,
  parameter int SETTLE_US     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             role_host_i,
  input  logic             enter_l1_i,
  input  logic             rwake_tok_i,
  input  logic             res_req_i,
  input  logic             far_resume_i,
  input  logic [CNT_W-1:0] hird_dur_i,
  input  logic             expire_i,
  output logic             tmr_start_o,
  output logic             tmr_run_o,
  output logic [CNT_W-1:0] tmr_limit_o,
  output logic             drive_o,
  output logic             ready_o,
  output logic             irq_o
);

  localparam logic [CNT_W-1:0] DEV_LIM    = CNT_W'(DEV_DRIVE_US);
  localparam logic [CNT_W-1:0] RWAKE_LIM  = CNT_W'(HOST_RWAKE_US);
  localparam logic [CNT_W-1:0] SETTLE_LIM = CNT_W'(SETTLE_US);

  rsm_state_e state_q, state_d;
  logic       rwake_q, rwake_d;
  logic       seen_q, seen_d;
  logic       irq_q, irq_d;

  always_comb begin
    state_d     = state_q;
    rwake_d     = rwake_q;
    seen_d      = seen_q;
    irq_d       = 1'b0;
    tmr_start_o = 1'b0;
    tmr_limit_o = '0;
    unique case (state_q)
      ST_ACTIVE: begin
        if (enter_l1_i) begin
          state_d = ST_L1;
          rwake_d = rwake_tok_i;
        end
      end
      ST_L1: begin
        seen_d = 1'b0;
        if (res_req_i) begin
          tmr_start_o = 1'b1;
          if (role_host_i) begin
            state_d     = ST_HST_DRV;
            tmr_limit_o = hird_dur_i;
          end else begin
            state_d     = ST_DEV_DRV;
            tmr_limit_o = DEV_LIM;
          end
        end else if (far_resume_i) begin
          if (role_host_i && rwake_q) begin
            state_d     = ST_HST_RW;
            tmr_start_o = 1'b1;
            tmr_limit_o = RWAKE_LIM;
          end else if (!role_host_i) begin
            state_d = ST_DEV_WAIT;
            seen_d  = 1'b1;
          end
        end
      end
      ST_DEV_DRV: begin
        if (far_resume_i) seen_d = 1'b1;
        if (expire_i) state_d = ST_DEV_WAIT;
      end
      ST_DEV_WAIT: begin
        if (far_resume_i) seen_d = 1'b1;
        if (seen_q && !far_resume_i) begin
          state_d     = ST_SETTLE;
          tmr_start_o = 1'b1;
          tmr_limit_o = SETTLE_LIM;
        end
      end
      ST_HST_DRV, ST_HST_RW: begin
        if (expire_i) begin
          state_d     = ST_SETTLE;
          tmr_start_o = 1'b1;
          tmr_limit_o = SETTLE_LIM;
        end
      end
      ST_SETTLE: begin
        if (expire_i) begin
          state_d = ST_ACTIVE;
          irq_d   = 1'b1;
        end
      end
      default: state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ACTIVE;
      rwake_q <= 1'b0;
      seen_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rwake_q <= rwake_d;
      seen_q  <= seen_d;
      irq_q   <= irq_d;
    end
  end

  always_comb begin
    tmr_run_o = (state_q == ST_DEV_DRV) || (state_q == ST_HST_DRV) ||
                (state_q == ST_HST_RW)  || (state_q == ST_SETTLE);
    drive_o   = (state_q == ST_DEV_DRV) || (state_q == ST_HST_DRV) ||
                (state_q == ST_HST_RW);
    ready_o   = (state_q == ST_ACTIVE);
    irq_o     = irq_q;
  end

  p_no_wake_without_perm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_L1 && role_host_i && !rwake_q && !res_req_i) |=> (state_q == ST_L1));

  p_wait_needs_far_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DEV_WAIT && !seen_q) |=> (state_q != ST_SETTLE));

  p_settle_follows_timed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_SETTLE) |-> $past(tmr_start_o));

endmodule

// File: rtl/lpm_resume_seq.sv
module lpm_resume_seq #(
  parameter int HIRD_W        = 4,
  parameter int HIRD_BASE_US  = 50,
  parameter int HIRD_STEP_US  = 75,
  parameter int DEV_DRIVE_US  = 50,
  parameter int HOST_RWAKE_US = 60,
  parameter int SETTLE_US     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              role_host_i,
  input  logic              enter_l1_i,
  input  logic              rwake_tok_i,
  input  logic              res_req_wr_i,
  input  logic [HIRD_W-1:0] hird_i,
  input  logic              far_resume_i,
  input  logic              tick_us_i,
  output logic              drive_resume_o,
  output logic              ready_o,
  output logic              resume_irq_o
);

  localparam int MAX_US = HIRD_BASE_US + HIRD_STEP_US * ((1 << HIRD_W) - 1);
  localparam int CNT_W  = $clog2(MAX_US + 1);

  logic [CNT_W-1:0] hird_dur;
  logic [CNT_W-1:0] tmr_limit;
  logic             tmr_start, tmr_run, tmr_expire;

  lpm_hird_decode #(
    .HIRD_W       (HIRD_W),
    .HIRD_BASE_US (HIRD_BASE_US),
    .HIRD_STEP_US (HIRD_STEP_US),
    .CNT_W        (CNT_W)
  ) u_dec (
    .hird_i (hird_i),
    .dur_o  (hird_dur)
  );

  lpm_us_timer #(
    .CNT_W (CNT_W)
  ) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (tmr_start),
    .run_i    (tmr_run),
    .tick_i   (tick_us_i),
    .limit_i  (tmr_limit),
    .expire_o (tmr_expire)
  );

  lpm_rsm_ctrl #(
    .CNT_W         (CNT_W),
    .DEV_DRIVE_US  (DEV_DRIVE_US),
    .HOST_RWAKE_US (HOST_RWAKE_US),
    .SETTLE_US     (SETTLE_US)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .role_host_i  (role_host_i),
    .enter_l1_i   (enter_l1_i),
    .rwake_tok_i  (rwake_tok_i),
    .res_req_i    (res_req_wr_i),
    .far_resume_i (far_resume_i),
    .hird_dur_i   (hird_dur),
    .expire_i     (tmr_expire),
    .tmr_start_o  (tmr_start),
    .tmr_run_o    (tmr_run),
    .tmr_limit_o  (tmr_limit),
    .drive_o      (drive_resume_o),
    .ready_o      (ready_o),
    .irq_o        (resume_irq_o)
  );

  p_drive_excl_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drive_resume_o |-> !ready_o);

  p_irq_on_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> resume_irq_o);

  p_irq_only_on_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resume_irq_o |-> (ready_o && !$past(ready_o)));

  p_req_ignored_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && res_req_wr_i && !enter_l1_i) |=> ready_o);

  p_suspend_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && enter_l1_i) |=> (!ready_o && !drive_resume_o));

endmodule

// File: tb/sim_lpm_resume_seq.sv
module sim_lpm_resume_seq;

  logic       clk;
  logic       rst_n;
  logic       role_host, enter_l1, rwake_tok, res_req, far_res, tick;
  logic [3:0] hird;
  logic       drive, ready, irq;

  int total;
  int bad;
  int drv_ticks;
  int settle_ticks;
  int irq_cnt;
  int irq_bad;
  int div;
  logic ready_prev;

  lpm_resume_seq u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .role_host_i    (role_host),
    .enter_l1_i     (enter_l1),
    .rwake_tok_i    (rwake_tok),
    .res_req_wr_i   (res_req),
    .hird_i         (hird),
    .far_resume_i   (far_res),
    .tick_us_i      (tick),
    .drive_resume_o (drive),
    .ready_o        (ready),
    .resume_irq_o   (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    tick = 1'b0;
    div  = 0;
    forever begin
      @(posedge clk);
      #1;
      div  = (div == 4) ? 0 : div + 1;
      tick = (div == 4);
    end
  end

  initial begin
    drv_ticks = 0; settle_ticks = 0; irq_cnt = 0; irq_bad = 0; ready_prev = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (tick && drive) drv_ticks++;
        if (tick && !drive && !ready) settle_ticks++;
        if (irq) irq_cnt++;
        if (irq != (ready && !ready_prev)) irq_bad++;
        ready_prev = ready;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!tick);
    @(posedge clk);
    #1;
  endtask

  task automatic wait_ready();
    do @(negedge clk); while (!ready);
  endtask

  task automatic pulse_req();
    res_req = 1'b1;
    @(posedge clk); #1;
    res_req = 1'b0;
  endtask

  task automatic do_suspend(input bit rw);
    wait_tick();
    enter_l1  = 1'b1;
    rwake_tok = rw;
    @(posedge clk); #1;
    enter_l1  = 1'b0;
    rwake_tok = 1'b0;
    @(negedge clk);
    check(ready == 1'b0 && drive == 1'b0, "R2 suspend entry", int'(ready), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(ready == 1'b1, "R1 ready after reset", int'(ready), 1);
    check(drive == 1'b0, "R1 drive after reset", int'(drive), 0);
    check(irq == 1'b0, "R1 irq after reset", int'(irq), 0);
  endtask

  task automatic t_ignore_active();
    int d0, i0;
    d0 = drv_ticks; i0 = irq_cnt;
    wait_tick();
    pulse_req();
    repeat (60) @(negedge clk);
    check(ready == 1'b1, "R9 request while operational keeps ready", int'(ready), 1);
    check(drv_ticks == d0, "R9 request while operational drives nothing", drv_ticks - d0, 0);
    check(irq_cnt == i0, "R9 request while operational no irq", irq_cnt - i0, 0);
  endtask

  task automatic t_dev_self();
    int d0, s0, i0;
    role_host = 1'b0;
    do_suspend(1'b0);
    wait_tick();
    d0 = drv_ticks; i0 = irq_cnt;
    pulse_req();
    repeat (100) @(posedge clk);
    #1 far_res = 1'b1;
    do @(negedge clk); while (drive);
    check(drv_ticks - d0 == 50, "R3 device drive length", drv_ticks - d0, 50);
    repeat (150) @(negedge clk);
    check(ready == 1'b0, "R4 device waits for far end to stop", int'(ready), 0);
    wait_tick();
    s0 = settle_ticks;
    far_res = 1'b0;
    wait_ready();
    check(settle_ticks - s0 == 10, "R4 device settle after far end stops", settle_ticks - s0, 10);
    check(irq_cnt - i0 == 1, "R10 irq count device self resume", irq_cnt - i0, 1);
  endtask

  task automatic t_dev_hostres();
    int d0, s0, i0;
    role_host = 1'b0;
    do_suspend(1'b1);
    wait_tick();
    d0 = drv_ticks; i0 = irq_cnt;
    far_res = 1'b1;
    repeat (200) @(negedge clk);
    check(ready == 1'b0, "R5 not ready while far end drives", int'(ready), 0);
    check(drv_ticks == d0, "R5 device does not drive on host resume", drv_ticks - d0, 0);
    wait_tick();
    s0 = settle_ticks;
    far_res = 1'b0;
    wait_ready();
    check(settle_ticks - s0 == 10, "R5 settle after host resume", settle_ticks - s0, 10);
    check(irq_cnt - i0 == 1, "R10 irq count host-driven resume", irq_cnt - i0, 1);
  endtask

  task automatic t_host_hird(input int n, input bit poke);
    int d0, s0, i0;
    role_host = 1'b1;
    do_suspend(1'b0);
    hird = 4'(n);
    wait_tick();
    d0 = drv_ticks; s0 = settle_ticks; i0 = irq_cnt;
    pulse_req();
    if (poke) begin
      repeat (40) @(posedge clk);
      #1;
      pulse_req();
    end
    wait_ready();
    check(drv_ticks - d0 == 50 + 75 * n, poke ? "R9 mid-exit request leaves drive length" :
          "R6 host drive length from hird", drv_ticks - d0, 50 + 75 * n);
    check(settle_ticks - s0 == 10, "R6 host settle after drive", settle_ticks - s0, 10);
    check(irq_cnt - i0 == 1, "R10 irq count host resume", irq_cnt - i0, 1);
  endtask

  task automatic t_host_rwake(input bit allowed);
    int d0, s0, i0;
    role_host = 1'b1;
    do_suspend(allowed);
    wait_tick();
    d0 = drv_ticks; s0 = settle_ticks; i0 = irq_cnt;
    far_res = 1'b1;
    repeat (250) @(posedge clk);
    #1 far_res = 1'b0;
    if (allowed) begin
      wait_ready();
      check(drv_ticks - d0 == 60, "R7 host remote wake drive length", drv_ticks - d0, 60);
      check(settle_ticks - s0 == 10, "R7 host remote wake settle", settle_ticks - s0, 10);
      check(irq_cnt - i0 == 1, "R10 irq count remote wake", irq_cnt - i0, 1);
    end else begin
      repeat (200) @(negedge clk);
      check(ready == 1'b0, "R8 unpermitted wake leaves link suspended", int'(ready), 0);
      check(drv_ticks == d0, "R8 unpermitted wake drives nothing", drv_ticks - d0, 0);
      check(irq_cnt == i0, "R8 unpermitted wake no irq", irq_cnt - i0, 0);
      hird = 4'd0;
      wait_tick();
      pulse_req();
      wait_ready();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; role_host = 1'b0; enter_l1 = 1'b0; rwake_tok = 1'b0;
    res_req = 1'b0; far_res = 1'b0; hird = 4'd0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_ignore_active();
    t_dev_self();
    t_dev_hostres();
    t_host_hird(0, 1'b0);
    t_host_hird(5, 1'b1);
    t_host_hird(15, 1'b0);
    t_host_rwake(1'b1);
    t_host_rwake(1'b0);
    repeat (5) @(negedge clk);
    check(irq_bad == 0, "R10 irq pulse only on ready rise", irq_bad, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule